// File: doc/BRIEF.md
# Sanitising Table Base Register

This block holds one 64-bit base register that describes where an interrupt table sits in memory and how it may be cached and shared. Software updates the register either with one 64-bit write or with a 32-bit write to one of its two halves. The half is picked by address bit 2. Each accepted write merges the new data with the stored value. The merged word then passes through a sanitiser before it is stored. The sanitiser turns disallowed shareability and cacheability codes into allowed ones and forces the reserved bits to zero. While the local table-enable input is high, every write is dropped.

A single parameter selects one of two layouts. The property layout and the pending layout differ in their reserved-bit masks. The pending layout also has a zero-fill flag at bit 62. This flag is stored but always reads back as 0. Reads are combinational. A read returns a byte slice of the register that starts at a byte offset and is a given number of bytes long.

Top module: `tbr_table_base`

## Requirements
- R1: A 32-bit write (wr_wide=0) replaces only the half picked by wr_hi (0 = bits 31:0, 1 = bits 63:32) with wr_data[31:0]. The other half keeps its stored value, apart from sanitising.
- R2: A 64-bit write (wr_wide=1) replaces the whole register with wr_data, apart from sanitising.
- R3: While lpi_en is high, a write leaves the register unchanged.
- R4: Shareability sits at bits 11:10. Code 2 (outer) is stored as 1 (inner). Codes 0, 1 and 3 are kept.
- R5: Inner cacheability sits at bits 9:7. Codes 0 and 1 (non-cacheable) are stored as 7 (read-allocate write-back). Every other code is kept.
- R6: Outer cacheability sits at bits 58:56. Codes 0 (same as inner) and 1 (non-cacheable) are kept. Every other code is stored as 0.
- R7: In the property layout (PEND_VARIANT=0), bits 63:59, 55:52 and 6:5 always read as zero.
- R8: In the pending layout (PEND_VARIANT=1), bits 63, 61:59, 55:52, 15:12 and 6:0 always read as zero.
- R9: In the pending layout, bit 62 (zero-fill flag) always reads as 0.
- R10: rd_data holds rd_len bytes of the register, starting at byte rd_off (zero-extended). rd_len 0 returns zero, and rd_len above 8 counts as 8. The read shows the stored value, so a write in the same cycle becomes visible only after the clock edge.
- R11: After reset the register reads as zero.
- R12: Sanitising is applied to the whole merged word on every accepted write. A write to the upper half therefore also remaps the fields in the lower half.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Write strobe |
| wr_wide | input | 1 | 1 = 64-bit write, 0 = 32-bit write |
| wr_hi | input | 1 | Half select for a 32-bit write (address bit 2) |
| wr_data | input | 64 | Write data (low 32 bits used for a 32-bit write) |
| lpi_en | input | 1 | Table enable; while high, writes are dropped |
| rd_off | input | 3 | Read byte offset |
| rd_len | input | 4 | Read length in bytes |
| rd_data | output | 64 | Read data, zero-extended |

## Verification
A read and a write can land in the same cycle. The bench checks the full-width read while a write is being presented, before the clock edge, and expects the old value. It checks the same read again after the edge and expects the sanitised new value. The write strobe and lpi_en can also be high together. The bench raises lpi_en randomly during writes and requires that a full read after the edge still returns the previous value.

// File: rtl/tbr_pkg.sv
// Shared field positions, codes and sanitising functions for the table base register.
// Assumes a fixed 64-bit register layout; only the variant masks differ.
package tbr_pkg;
    localparam int REG_W   = 64;
    localparam int HALF_W  = REG_W / 2;
    localparam int BYTES   = REG_W / 8;
    localparam int OFF_W   = $clog2(BYTES);
    localparam int LEN_W   = OFF_W + 1;

    localparam int SH_LO   = 10;
    localparam int IC_LO   = 7;
    localparam int OC_LO   = 56;
    localparam int ZF_BIT  = 62;

    localparam logic [1:0] SH_INNER = 2'd1;
    localparam logic [1:0] SH_OUTER = 2'd2;
    localparam logic [2:0] IC_NCNB  = 3'd0;
    localparam logic [2:0] IC_NC    = 3'd1;
    localparam logic [2:0] IC_RAWB  = 3'd7;
    localparam logic [2:0] OC_SAME  = 3'd0;
    localparam logic [2:0] OC_NC    = 3'd1;

    localparam logic [REG_W-1:0] PROP_RES0 = 64'hF8F0_0000_0000_0060;
    localparam logic [REG_W-1:0] PEND_RES0 = 64'hB8F0_0000_0000_F07F;

    // Outer shareable becomes inner shareable.
    function automatic logic [1:0] fix_share(input logic [1:0] c);
        return (c == SH_OUTER) ? SH_INNER : c;
    endfunction

    // Any non-cacheable inner code becomes read-allocate write-back.
    function automatic logic [2:0] fix_inner(input logic [2:0] c);
        return (c == IC_NCNB || c == IC_NC) ? IC_RAWB : c;
    endfunction

    // Only same-as-inner and non-cacheable survive on the outer side.
    function automatic logic [2:0] fix_outer(input logic [2:0] c);
        return (c == OC_SAME || c == OC_NC) ? c : OC_SAME;
    endfunction
endpackage

// File: rtl/tbr_merge.sv
// Merges write data into the stored register: the full word or one 32-bit half.
// Assumes the caller only uses the result when a write is accepted.
module tbr_merge
    import tbr_pkg::*;
(
    input  logic [REG_W-1:0] cur,
    input  logic [REG_W-1:0] wdata,
    input  logic             wide,
    input  logic             hi,
    output logic [REG_W-1:0] merged
);
    // Pick whole-word or half-word replacement.
    always_comb begin
        if (wide)
            merged = wdata;
        else if (hi)
            merged = {wdata[HALF_W-1:0], cur[HALF_W-1:0]};
        else
            merged = {cur[REG_W-1:HALF_W], wdata[HALF_W-1:0]};
    end
endmodule

// File: rtl/tbr_sanitise.sv
// Rewrites disallowed shareability/cacheability codes and clears reserved bits.
// PEND_VARIANT picks the reserved mask; the function is idempotent.
module tbr_sanitise
    import tbr_pkg::*;
#(
    parameter bit PEND_VARIANT = 1'b0
) (
    input  logic [REG_W-1:0] raw,
    output logic [REG_W-1:0] clean
);
    logic [REG_W-1:0] res0;
    logic [REG_W-1:0] remapped;

    generate
        if (PEND_VARIANT) begin : g_pend
            assign res0 = PEND_RES0;
        end else begin : g_prop
            assign res0 = PROP_RES0;
        end
    endgenerate

    // Replace the three attribute fields with their legal versions.
    always_comb begin
        remapped = raw;
        remapped[SH_LO+:2] = fix_share(raw[SH_LO+:2]);
        remapped[IC_LO+:3] = fix_inner(raw[IC_LO+:3]);
        remapped[OC_LO+:3] = fix_outer(raw[OC_LO+:3]);
    end

    assign clean = remapped & ~res0;
endmodule

// File: rtl/tbr_read.sv
// Byte-slice read port: hides the zero-fill flag in the pending layout, then
// returns rd_len bytes from byte offset rd_off, zero-extended.
module tbr_read
    import tbr_pkg::*;
#(
    parameter bit PEND_VARIANT = 1'b0
) (
    input  logic [REG_W-1:0] stored,
    input  logic [OFF_W-1:0] off,
    input  logic [LEN_W-1:0] len,
    output logic [REG_W-1:0] data
);
    logic [REG_W-1:0] vis;
    logic [REG_W-1:0] shifted;
    logic [LEN_W-1:0] len_eff;

    generate
        if (PEND_VARIANT) begin : g_hide
            always_comb begin
                vis = stored;
                vis[ZF_BIT] = 1'b0;
            end
        end else begin : g_plain
            assign vis = stored;
        end
    endgenerate

    assign shifted = vis >> {off, 3'b000};
    assign len_eff = (len > LEN_W'(BYTES)) ? LEN_W'(BYTES) : len;

    generate
        for (genvar b = 0; b < BYTES; b++) begin : g_byte
            assign data[b*8+:8] = (LEN_W'(b) < len_eff) ? shifted[b*8+:8] : 8'h00;
        end
    endgenerate
endmodule

// File: rtl/tbr_table_base.sv
// Sanitising 64-bit table base register. Accepts full or half writes when
// lpi_en is low, sanitises every accepted write and serves byte-slice reads.
// Assumes wr_hi is ignored for full-width writes.
module tbr_table_base
    import tbr_pkg::*;
#(
    parameter bit PEND_VARIANT = 1'b0
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                wr_en,
    input  logic                wr_wide,
    input  logic                wr_hi,
    input  logic [REG_W-1:0]    wr_data,
    input  logic                lpi_en,
    input  logic [OFF_W-1:0]    rd_off,
    input  logic [LEN_W-1:0]    rd_len,
    output logic [REG_W-1:0]    rd_data
);
    logic [REG_W-1:0] stored;
    logic [REG_W-1:0] merged;
    logic [REG_W-1:0] clean;
    logic             take;

    assign take = wr_en && !lpi_en;

    tbr_merge u_merge (
        .cur    (stored),
        .wdata  (wr_data),
        .wide   (wr_wide),
        .hi     (wr_hi),
        .merged (merged)
    );

    tbr_sanitise #(.PEND_VARIANT(PEND_VARIANT)) u_san (
        .raw   (merged),
        .clean (clean)
    );

    // Register update: clear on reset, load sanitised word on an accepted write.
    always_ff @(posedge clk) begin
        if (!rst_n)
            stored <= '0;
        else if (take)
            stored <= clean;
    end

    tbr_read #(.PEND_VARIANT(PEND_VARIANT)) u_read (
        .stored (stored),
        .off    (rd_off),
        .len    (rd_len),
        .data   (rd_data)
    );

    assert_lo_half_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (take && !wr_wide && !wr_hi) |=> (stored[63:32] == $past(stored[63:32]))
                                         && (stored[31:16] == $past(wr_data[31:16])));
    assert_hi_half_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (take && !wr_wide && wr_hi) |=> stored[51:32] == $past(wr_data[19:0]));
    assert_full_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (take && wr_wide) |=> stored[51:16] == $past(wr_data[51:16]));
    assert_blocked_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && lpi_en) |=> $stable(stored));
    assert_share_R4: assert property (@(posedge clk) disable iff (!rst_n)
        stored[SH_LO+:2] != SH_OUTER);
    assert_inner_R5: assert property (@(posedge clk) disable iff (!rst_n)
        take |=> stored[IC_LO+:3] > IC_NC);
    assert_outer_R6: assert property (@(posedge clk) disable iff (!rst_n)
        stored[OC_LO+:3] <= OC_NC);
    assert_rdlen0_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_len == '0) |-> (rd_data == '0));

    generate
        if (PEND_VARIANT) begin : g_chk_pend
            assert_res0_R8: assert property (@(posedge clk) disable iff (!rst_n)
                (stored & PEND_RES0) == '0);
            assert_zf_hidden_R9: assert property (@(posedge clk) disable iff (!rst_n)
                (rd_off == 3'd0 && rd_len >= 4'd8) |-> !rd_data[ZF_BIT]);
        end else begin : g_chk_prop
            assert_res0_R7: assert property (@(posedge clk) disable iff (!rst_n)
                (stored & PROP_RES0) == '0);
        end
    endgenerate
endmodule

// File: tb/test_tbr_table_base.sv
`timescale 1ns/1ps
module test_tbr_table_base;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0, wr_wide = 1'b0, wr_hi = 1'b0, lpi_en = 1'b0;
    logic [63:0] wr_data = '0;
    logic [2:0]  rd_off = '0;
    logic [3:0]  rd_len = 4'd8;
    logic [63:0] rd_pend, rd_prop;
    logic [63:0] m_pend = '0, m_prop = '0;
    int          n_chk = 0, n_fail = 0;
    bit          done = 0;

    always #2 clk = ~clk;

    tbr_table_base #(.PEND_VARIANT(1'b1)) i_tbr_table_base (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_wide(wr_wide), .wr_hi(wr_hi),
        .wr_data(wr_data), .lpi_en(lpi_en), .rd_off(rd_off), .rd_len(rd_len),
        .rd_data(rd_pend));
    tbr_table_base #(.PEND_VARIANT(1'b0)) i_tbr_table_base_prop (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_wide(wr_wide), .wr_hi(wr_hi),
        .wr_data(wr_data), .lpi_en(lpi_en), .rd_off(rd_off), .rd_len(rd_len),
        .rd_data(rd_prop));

    // Model of the stored word after sanitising (R4, R5, R6, R7, R8).
    function automatic logic [63:0] san(input logic [63:0] v, input bit pend);
        logic [63:0] r = v;
        if (r[11:10] == 2'd2) r[11:10] = 2'd1;
        if (r[9:7] <= 3'd1) r[9:7] = 3'd7;
        if (r[58:56] > 3'd1) r[58:56] = 3'd0;
        r &= pend ? ~64'hB8F0_0000_0000_F07F : ~64'hF8F0_0000_0000_0060;
        return r;
    endfunction

    // Expected read slice (R9, R10).
    function automatic logic [63:0] ext(input logic [63:0] v, input logic [2:0] off,
                                        input logic [3:0] len, input bit pend);
        logic [63:0] r = v;
        int le = (len > 4'd8) ? 8 : int'(len);
        if (pend) r[62] = 1'b0;
        r = r >> (int'(off) * 8);
        for (int i = 0; i < 8; i++) if (i >= le) r[i*8+:8] = 8'h00;
        return r;
    endfunction

    task automatic chk(input string tag, input logic [63:0] got, input logic [63:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s got=%h exp=%h", tag, got, exp);
        end
    endtask

    task automatic rd_chk(input logic [2:0] off, input logic [3:0] len, input string tag);
        rd_off = off; rd_len = len;
        #1;
        chk({tag, " pend"}, rd_pend, ext(m_pend, off, len, 1'b1));
        chk({tag, " prop"}, rd_prop, ext(m_prop, off, len, 1'b0));
    endtask

    task automatic wr(input logic [63:0] d, input bit wide, input bit hi, input bit lpi);
        logic [63:0] mp, mq;
        @(negedge clk);
        wr_en = 1'b1; wr_data = d; wr_wide = wide; wr_hi = hi; lpi_en = lpi;
        rd_chk(3'd0, 4'd8, "R10 same-cycle old value");
        @(posedge clk);
        if (!lpi) begin
            mp = wide ? d : hi ? {d[31:0], m_pend[31:0]} : {m_pend[63:32], d[31:0]};
            mq = wide ? d : hi ? {d[31:0], m_prop[31:0]} : {m_prop[63:32], d[31:0]};
            m_pend = san(mp, 1'b1);
            m_prop = san(mq, 1'b0);
        end
        @(negedge clk);
        wr_en = 1'b0; lpi_en = 1'b0;
    endtask

    initial begin
        #(4 * 200000);
        if (!done) begin
            n_fail++; n_chk++;
            $display("FAIL watchdog expired");
            $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd1234));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        rd_chk(3'd0, 4'd8, "R11 reset value");
        // Upper-half write remaps lower fields too.
        wr(64'h0000_0000_0000_0001, 1'b0, 1'b1, 1'b0);
        rd_chk(3'd0, 4'd8, "R12 upper write sanitises lower half");
        // Full write with every illegal code and all reserved bits set.
        wr(64'hFFFF_FFFF_FFFF_FFFF & ~64'h0700_0000_0000_0F80 | 64'h0500_0000_0000_0800,
           1'b1, 1'b0, 1'b0);
        rd_chk(3'd0, 4'd8, "R2 R4 R6 R7 R8 R9 full write");
        rd_chk(3'd7, 4'd1, "R9 zero-fill byte");
        wr(64'h0, 1'b1, 1'b0, 1'b0);
        rd_chk(3'd0, 4'd8, "R5 inner 0 remapped");
        wr(64'h0100_0000_0000_0E80, 1'b1, 1'b0, 1'b0);
        rd_chk(3'd0, 4'd8, "R4 R5 R6 legal codes kept");
        wr(64'h1234_5678_9ABC_DEF0, 1'b0, 1'b0, 1'b0);
        rd_chk(3'd0, 4'd8, "R1 lower half write");
        wr(64'h0000_0000_0BAD_CAFE, 1'b0, 1'b1, 1'b0);
        rd_chk(3'd0, 4'd8, "R1 upper half write");
        wr(64'hFFFF_FFFF_FFFF_FFFF, 1'b1, 1'b0, 1'b1);
        rd_chk(3'd0, 4'd8, "R3 write blocked by lpi_en");
        rd_chk(3'd2, 4'd0, "R10 zero length");
        rd_chk(3'd3, 4'd15, "R10 oversize length");
        rd_chk(3'd4, 4'd4, "R10 upper word slice");
        for (int k = 0; k < 400; k++) begin
            wr({$urandom, $urandom}, 1'($urandom), 1'($urandom), ($urandom % 4) == 0);
            rd_chk(3'd0, 4'd8, "R1 R2 R3 R4 R5 R6 R7 R8 random write");
            rd_chk(3'($urandom), 4'($urandom % 10), "R10 random slice");
        end
        done = 1;
        $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
        $finish;
    end
endmodule